// File: doc/BRIEF.md
# Pseudo-Random Bus Traffic Exerciser

This block is a bus initiator that keeps an interconnect and its targets busy with a steady stream of single Wishbone transfers. A 32-bit linear feedback shift register is the only source of variety. Its state at the moment a transfer is issued sets the target region, the read/write direction, the word offset inside the region and the write data. The register steps forward only after the transfer has been answered, so every request field holds still for as long as the target stalls.

Handshake rules: the request is valid while `wb_cyc_o` and `wb_stb_o` are high, and `wb_ack_i` or `wb_err_i` acts as ready. A target applies back-pressure simply by withholding both, and the request then waits unchanged for any number of cycles. After every response the initiator inserts one idle cycle before it raises the next request. Read data is not examined.

Each target region has its own counter of finished transfers. When a counter reaches a fixed number of accesses, the LED bit for that target flips and the counter starts again from zero. This gives a visible sign that traffic is reaching every target.

Top module: `rnd_bus_exerciser`

## Requirements
- R1: While synchronous reset is high, `wb_cyc_o`, `wb_stb_o` and every `led_o` bit are 0. Every access counter clears, and the shift register reloads `SEED`, so the first transfer after reset is built from `SEED`.
- R2: The region index is state bits [TGT_W-1:0] and the word offset is the next REGION_BITS-2 bits. `wb_adr_o` = BASE_ADDR + index·2^REGION_BITS + 4·offset, so it is always word aligned. `wb_sel_o` is all ones.
- R3: `wb_cyc_o` and `wb_stb_o` are equal. Once raised, they and `wb_adr_o`, `wb_we_o` and `wb_dat_o` stay unchanged until a cycle in which `wb_ack_i` or `wb_err_i` is high.
- R4: The request drops on the clock edge that samples a response and stays low for exactly one cycle, then rises again. The first request rises on the first clock edge at which reset is low.
- R5: `wb_we_o` is state bit 31 (1 = write), and `wb_dat_o` is the full 32-bit state.
- R6: The shift register is a Fibonacci type with taps 32, 22, 2 and 1. The next state is {s[30:0], s[31]^s[21]^s[1]^s[0]}. It advances exactly once per answered transfer.
- R7: Each region counts its answered transfers. Every TOGGLE_COUNT-th answered transfer to region t (default 16,384) inverts `led_o[t]` on the edge that ends that transfer. No other event changes any LED.
- R8: An error response ends a transfer exactly like an acknowledge: it counts toward R7 and advances the state. A cycle with both responses high counts once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wb_cyc_o | output | 1 | Bus cycle active |
| wb_stb_o | output | 1 | Request strobe (request valid) |
| wb_we_o | output | 1 | 1 = write, 0 = read |
| wb_adr_o | output | ADDR_W | Byte address |
| wb_dat_o | output | 32 | Write data |
| wb_sel_o | output | 4 | Byte lane selects |
| wb_ack_i | input | 1 | Normal completion (ready) |
| wb_err_i | input | 1 | Error completion (ready) |
| led_o | output | N_TGT | Per-target toggle outputs |

## Verification
The request fields appear on the first clock edge after reset is released, or one cycle after the edge that took the previous response, because nothing registers them apart from the shift register itself. LED flips, the request drop and the state advance all land on the same edge that samples the response. The bench drives the response on a falling edge and samples every output on the following falling edge, which is half a clock after the edge at which each result is due. It checks the request fields when it first sees `wb_cyc_o` high, checks that they stay stable on every stalled cycle, and checks that the bus is idle and the LEDs match its model at the falling edge right after each response.

// File: rtl/rbx_pkg.sv
package rbx_pkg;
  localparam int STATE_W = 32;

  typedef enum logic {
    XF_IDLE = 1'b0,
    XF_BUSY = 1'b1
  } xfer_state_e;

  function automatic logic [STATE_W-1:0] state_step(input logic [STATE_W-1:0] s);
    return {s[STATE_W-2:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction
endpackage

// File: rtl/rbx_lfsr.sv
module rbx_lfsr
  import rbx_pkg::*;
#(
  parameter logic [STATE_W-1:0] SEED = 32'hACE1_2468
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               adv,
  output logic [STATE_W-1:0] state
);
  always_ff @(posedge clk) begin
    if (rst)      state <= SEED;
    else if (adv) state <= state_step(state);
  end
endmodule

// File: rtl/rbx_xfer_fsm.sv
module rbx_xfer_fsm
  import rbx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic resp,
  output logic req,
  output logic done
);
  xfer_state_e st;

  always_ff @(posedge clk) begin
    if (rst) st <= XF_IDLE;
    else begin
      unique case (st)
        XF_IDLE: st <= XF_BUSY;
        XF_BUSY: if (resp) st <= XF_IDLE;
        default: st <= XF_IDLE;
      endcase
    end
  end

  assign req  = (st == XF_BUSY);
  assign done = req && resp;
endmodule

// File: rtl/rbx_hit_counter.sv
module rbx_hit_counter #(
  parameter int LIMIT = 16384
) (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  output logic led
);
  localparam int CNT_W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      led <= 1'b0;
    end else if (hit) begin
      if (cnt == LAST) begin
        cnt <= '0;
        led <= ~led;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rnd_bus_exerciser.sv
module rnd_bus_exerciser
  import rbx_pkg::*;
#(
  parameter int                 ADDR_W       = 32,
  parameter int                 N_TGT        = 4,
  parameter int                 REGION_BITS  = 12,
  parameter logic [ADDR_W-1:0]  BASE_ADDR    = '0,
  parameter int                 TOGGLE_COUNT = 16384,
  parameter logic [31:0]        SEED         = 32'hACE1_2468
) (
  input  logic                  clk,
  input  logic                  rst,
  output logic                  wb_cyc_o,
  output logic                  wb_stb_o,
  output logic                  wb_we_o,
  output logic [ADDR_W-1:0]     wb_adr_o,
  output logic [STATE_W-1:0]    wb_dat_o,
  output logic [STATE_W/8-1:0]  wb_sel_o,
  input  logic                  wb_ack_i,
  input  logic                  wb_err_i,
  output logic [N_TGT-1:0]      led_o
);
  localparam int TGT_W = (N_TGT > 1) ? $clog2(N_TGT) : 1;
  localparam int OFF_W = REGION_BITS - 2;

  logic [STATE_W-1:0] state;
  logic               req;
  logic               done;
  logic [TGT_W-1:0]   tgt;
  logic [OFF_W-1:0]   word_off;

  rbx_lfsr #(.SEED(SEED)) lfsr_i (
    .clk(clk), .rst(rst), .adv(done), .state(state)
  );

  rbx_xfer_fsm fsm_i (
    .clk(clk), .rst(rst), .resp(wb_ack_i | wb_err_i), .req(req), .done(done)
  );

  // State only moves on completion, so all fields stay put while stalled.
  assign tgt      = state[TGT_W-1:0];
  assign word_off = state[TGT_W +: OFF_W];

  assign wb_cyc_o = req;
  assign wb_stb_o = req;
  assign wb_we_o  = state[STATE_W-1];
  assign wb_dat_o = state;
  assign wb_sel_o = '1;
  assign wb_adr_o = BASE_ADDR
                  + (ADDR_W'(tgt) << REGION_BITS)
                  + ADDR_W'({word_off, 2'b00});

  for (genvar t = 0; t < N_TGT; t++) begin : g_tgt
    rbx_hit_counter #(.LIMIT(TOGGLE_COUNT)) cnt_i (
      .clk(clk), .rst(rst),
      .hit(done && (tgt == TGT_W'(t))),
      .led(led_o[t])
    );
  end
endmodule

// File: rtl/rbx_checker.sv
module rbx_checker #(
  parameter int ADDR_W = 32,
  parameter int N_TGT  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              cyc,
  input logic              stb,
  input logic              we,
  input logic [ADDR_W-1:0] adr,
  input logic [31:0]       dat,
  input logic [3:0]        sel,
  input logic              ack,
  input logic              err,
  input logic [N_TGT-1:0]  led
);
  p_idle_in_reset_r1: assert property (@(posedge clk) rst |=> (!cyc && !stb && led == '0));

  p_sel_aligned_r2: assert property (@(posedge clk) disable iff (rst)
    cyc |-> (&sel && adr[1:0] == 2'b00));

  p_strobe_pair_r3: assert property (@(posedge clk) disable iff (rst) cyc == stb);

  p_hold_stalled_r3: assert property (@(posedge clk) disable iff (rst)
    (cyc && !ack && !err) |=> (cyc && $stable(adr) && $stable(we) && $stable(dat)));

  p_gap_after_resp_r4: assert property (@(posedge clk) disable iff (rst)
    (cyc && (ack || err)) |=> !cyc);

  p_restart_r4: assert property (@(posedge clk) disable iff (rst)
    (!cyc && !$past(rst)) |=> cyc);

  p_led_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !(cyc && (ack || err)) |=> $stable(led));

  p_led_single_r7: assert property (@(posedge clk) disable iff (rst)
    $countones(led ^ $past(led)) <= 1);
endmodule

bind rnd_bus_exerciser rbx_checker #(.ADDR_W(ADDR_W), .N_TGT(N_TGT)) chk_i (
  .clk(clk), .rst(rst), .cyc(wb_cyc_o), .stb(wb_stb_o), .we(wb_we_o),
  .adr(wb_adr_o), .dat(wb_dat_o), .sel(wb_sel_o), .ack(wb_ack_i),
  .err(wb_err_i), .led(led_o)
);

// File: tb/rnd_bus_exerciser_tb.sv
module rnd_bus_exerciser_tb_top;
  localparam int          LIMIT = 8;
  localparam int          NT    = 4;
  localparam logic [31:0] SEED  = 32'hACE1_2468;
  localparam logic [31:0] BASE  = 32'h0001_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ack = 1'b0;
  logic        err = 1'b0;
  logic        cyc, stb, we;
  logic [31:0] adr, dat;
  logic [3:0]  sel;
  logic [NT-1:0] led;

  always #10 clk = ~clk;

  rnd_bus_exerciser #(
    .ADDR_W(32), .N_TGT(NT), .REGION_BITS(12), .BASE_ADDR(BASE),
    .TOGGLE_COUNT(LIMIT), .SEED(SEED)
  ) dut_i (
    .clk(clk), .rst(rst), .wb_cyc_o(cyc), .wb_stb_o(stb), .wb_we_o(we),
    .wb_adr_o(adr), .wb_dat_o(dat), .wb_sel_o(sel), .wb_ack_i(ack),
    .wb_err_i(err), .led_o(led)
  );

  int n_tests = 0;
  int n_fail  = 0;

  logic [31:0]   m_state;
  int            m_cnt [NT];
  logic [NT-1:0] m_led;

  bit g_long = 0, g_err = 0, g_both = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  function automatic logic [31:0] exp_adr(input logic [31:0] s);
    return BASE + 32'(s[1:0]) * 32'd4096 + 32'(s[11:2]) * 32'd4;
  endfunction

  task automatic model_reset();
    m_state = SEED;
    m_led   = '0;
    for (int t = 0; t < NT; t++) m_cnt[t] = 0;
  endtask

  task automatic run(input int nxfer);
    int done_n = 0;
    int wait_left = 0;
    bit busy = 0, ending = 0, prev_cyc = 0;
    logic [31:0] h_adr, h_dat;
    logic h_we;
    while (done_n < nxfer) begin
      @(negedge clk);
      if (ending) begin
        int t;
        chk(!cyc && !stb, "R4", "request low after response", {62'b0, cyc, stb}, 64'd0);
        t = int'(m_state[1:0]);
        m_cnt[t]++;
        if (m_cnt[t] % LIMIT == 0) m_led[t] = ~m_led[t];
        m_state = nxt(m_state);
        chk(led == m_led, "R7", "led after response", 64'(led), 64'(m_led));
        ack = 0; err = 0;
        ending = 0; busy = 0;
        done_n++;
      end else if (busy) begin
        chk(cyc && stb && adr == h_adr && dat == h_dat && we == h_we, "R3",
            "request held while stalled", {adr, dat}, {h_adr, h_dat});
        chk(led == m_led, "R7", "led steady during stall", 64'(led), 64'(m_led));
      end else if (cyc) begin
        chk(!prev_cyc, "R4", "idle cycle before request", 64'(prev_cyc), 64'd0);
        chk(adr == exp_adr(m_state) && sel == 4'hF, "R2", "address/sel",
            {adr, 28'd0, sel}, {exp_adr(m_state), 28'd0, 4'hF});
        chk(we == m_state[31] && dat == m_state, "R5", "direction/data (R6 state)",
            {31'd0, we, dat}, {31'd0, m_state[31], m_state});
        chk(stb, "R3", "strobe with cycle", 64'(stb), 64'd1);
        busy = 1; h_adr = adr; h_dat = dat; h_we = we;
        wait_left = g_long ? 12 : int'($urandom_range(0, 3));
      end else begin
        chk(led == m_led, "R7", "led while idle", 64'(led), 64'(m_led));
      end
      if (busy && !ending) begin
        if (wait_left == 0) begin
          if (g_both) begin ack = 1; err = 1; end
          else if (g_err || $urandom_range(0, 7) == 0) begin ack = 0; err = 1; end
          else begin ack = 1; err = 0; end
          ending = 1;
        end else begin
          wait_left--;
        end
      end
      prev_cyc = cyc;
    end
  endtask

  task automatic do_reset();
    rst = 1; ack = 0; err = 0;
    repeat (3) @(negedge clk);
    chk(!cyc && !stb, "R1", "request idle in reset", {62'b0, cyc, stb}, 64'd0);
    chk(led == '0, "R1", "leds clear in reset", 64'(led), 64'd0);
    model_reset();
    rst = 0;
    @(negedge clk);
    chk(cyc, "R4", "first request on first edge out of reset", 64'(cyc), 64'd1);
    chk(adr == exp_adr(SEED) && dat == SEED, "R1", "first request from seed",
        {adr, dat}, {exp_adr(SEED), SEED});
  endtask

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    do_reset();
    // Directed: long stalls on the first transfers (back-pressure).
    g_long = 1; run(3);
    g_long = 0; run(300);
    // Directed: error-only completions still count and advance (R8).
    g_err = 1; run(24);
    g_err = 0;
    // Directed: both responses in one cycle count once (R8).
    g_both = 1; run(16);
    g_both = 0; run(100);
    chk(m_led != '0 || led != '0, "R7", "some led toggled during run", 64'(led), 64'(m_led));
    // Reset mid-run clears counters, leds and restarts the sequence.
    do_reset();
    run(80);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule